// File: doc/BRIEF.md
# Three-Level Line Slicer and Transition Decoder

This block turns a stream of signed, digitized samples from a three-level line back into binary data. One sample arrives per recovered symbol clock, qualified by a valid strobe. Each sample is compared against an upper and a lower threshold and becomes one of three levels: positive, zero or negative. The decoded bit does not depend on which level was seen. It depends only on whether the level moved away from the level of the previous accepted sample. A move gives a '1' and no move gives a '0'.

The first sample after reset, or the sample that arrives together with a resync request, only sets the reference level and produces no bit. The decoder also reports two line faults. The first is a direct swing between the positive and the negative level, which a valid encoder never produces. The second is a run of identical levels longer than the coding allows. Both thresholds can be changed at run time and return to plus and minus half of full scale at reset. For a SAMPLE_W-bit input, full scale is 2^(SAMPLE_W-2).

Top module: `tlv_rx_decode`

## Requirements
- R1: A sample strictly greater than the upper threshold slices to +1, and a sample strictly less than the lower threshold slices to -1. Any other sample slices to 0. `lvl_out` gives the level of the latest accepted sample, encoded as +1 = 2'b01, 0 = 2'b00 and -1 = 2'b11.
- R2: At reset the thresholds are +2^(SAMPLE_W-3) and -2^(SAMPLE_W-3) (+128 and -128 for the default width). A cycle with `thr_wr` high loads both `thr_hi` and `thr_lo`. The new values apply to samples from the following cycle on, so a sample in the write cycle is still sliced with the old values.
- R3: For each accepted sample that is not a reference load, `bit_valid` is high for exactly one cycle, in the cycle after the sample. At the same time `bit_out` is 1 if the sliced level differs from the previous accepted level and 0 if it is equal.
- R4: The first accepted sample after reset, and a sample accepted while `resync` is high, only load the reference level. They update `lvl_out` but leave `bit_valid` low. The next sample is compared against this reference.
- R5: Cycles with `samp_valid` low produce no bit, and they leave the reference level and the run count unchanged.
- R6: `jump_err` is high together with the decoded bit when the level moved directly from +1 to -1 or from -1 to +1.
- R7: The run count includes the reference symbol. `run_err` is high together with the decoded bit when the symbol extends a run of one level beyond MAX_RUN symbols (default 3), so the fourth and every later identical symbol flags it.
- R8: While reset is asserted, `bit_valid`, `bit_out`, `jump_err` and `run_err` are 0 and `lvl_out` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Treat the next accepted sample as a new reference |
| samp_valid | input | 1 | Sample strobe |
| samp_data | input | SAMPLE_W | Signed two's-complement line sample |
| thr_wr | input | 1 | Load both thresholds |
| thr_hi | input | SAMPLE_W | New upper threshold, signed |
| thr_lo | input | SAMPLE_W | New lower threshold, signed |
| bit_valid | output | 1 | Decoded bit strobe |
| bit_out | output | 1 | Decoded bit (1 = level changed) |
| lvl_out | output | 2 | Sliced level of the latest accepted sample |
| jump_err | output | 1 | Direct swing between +1 and -1 |
| run_err | output | 1 | Run of one level longer than MAX_RUN |

## Verification
A corrupted reference level shows at the ports on the very next accepted sample. That sample comes out with the wrong `bit_out`, and it can also raise a false `jump_err` or `run_err`. A run counter that is off by one moves the first `run_err` one symbol early or late inside a single run of identical levels. A threshold register holding a stale or wrong value makes `lvl_out` disagree on samples placed at and just beyond each threshold. The bench therefore walks samples sitting exactly on the thresholds, checks the reference against samples taken after idle gaps, a resync and a reset, and compares every output in the cycle after each sample.

// File: rtl/tlv_pkg.sv
package tlv_pkg;

  // Level codes: two's complement of the level value
  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_POS  = 2'b01,
    LV_NEG  = 2'b11
  } lvl_e;

  // Direct swing between the two outer levels
  function automatic logic is_jump(input lvl_e prev, input lvl_e curr);
    return ((prev == LV_POS) && (curr == LV_NEG)) ||
           ((prev == LV_NEG) && (curr == LV_POS));
  endfunction

endpackage

// File: rtl/tlv_thr_regs.sv
module tlv_thr_regs #(
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic signed [SAMPLE_W-1:0] hi_in,
  input  logic signed [SAMPLE_W-1:0] lo_in,
  output logic signed [SAMPLE_W-1:0] hi_q,
  output logic signed [SAMPLE_W-1:0] lo_q
);

  // Half of full scale, where full scale is 2^(SAMPLE_W-2)
  localparam int HALF_I = 1 << (SAMPLE_W - 3);
  localparam logic signed [SAMPLE_W-1:0] HI_DEF = SAMPLE_W'(HALF_I);
  localparam logic signed [SAMPLE_W-1:0] LO_DEF = SAMPLE_W'(-HALF_I);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= HI_DEF;
      lo_q <= LO_DEF;
    end else if (wr_en) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  // R2: thresholds move only on a write
  p_thr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/tlv_slicer.sv
module tlv_slicer
  import tlv_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] thr_hi,
  input  logic signed [SAMPLE_W-1:0] thr_lo,
  output lvl_e                       lvl
);

  // Strict comparisons: a sample sitting on a threshold stays at zero
  function automatic lvl_e slice(input logic signed [SAMPLE_W-1:0] s,
                                 input logic signed [SAMPLE_W-1:0] hi,
                                 input logic signed [SAMPLE_W-1:0] lo);
    if (s > hi)      return LV_POS;
    else if (s < lo) return LV_NEG;
    else             return LV_ZERO;
  endfunction

  assign lvl = slice(sample, thr_hi, thr_lo);

endmodule

// File: rtl/tlv_run_mon.sv
module tlv_run_mon #(
  parameter int MAX_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_ref,
  input  logic step,
  input  logic same,
  output logic run_over
);

  localparam int CNT_W = $clog2(MAX_RUN + 2);
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(MAX_RUN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RUN);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // The symbol now compared would make the run longer than MAX_RUN
  assign run_over = step && same && (cnt_q >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_ref) begin
      cnt_q <= ONE;
    end else if (step) begin
      if (!same)            cnt_q <= ONE;
      else if (cnt_q != CAP) cnt_q <= cnt_q + ONE;
    end
  end

  // R7: a reference load starts a run of length one
  p_reload_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ref |=> (cnt_q == ONE));

  // R7: a run break always restarts the count at one
  p_break_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !same && !load_ref) |=> (cnt_q == ONE));

endmodule

// File: rtl/tlv_rx_decode.sv
module tlv_rx_decode
  import tlv_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int MAX_RUN  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                resync,
  input  logic                samp_valid,
  input  logic [SAMPLE_W-1:0] samp_data,
  input  logic                thr_wr,
  input  logic [SAMPLE_W-1:0] thr_hi,
  input  logic [SAMPLE_W-1:0] thr_lo,
  output logic                bit_valid,
  output logic                bit_out,
  output logic [1:0]          lvl_out,
  output logic                jump_err,
  output logic                run_err
);

  logic signed [SAMPLE_W-1:0] hi_q, lo_q;
  lvl_e lvl_now, lvl_q;
  logic have_ref_q;

  // Named internal events
  logic ref_load, cmp_step, changed, jump_now, run_over;

  tlv_thr_regs #(.SAMPLE_W(SAMPLE_W)) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (thr_wr),
    .hi_in (thr_hi),
    .lo_in (thr_lo),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
  );

  tlv_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
    .sample (samp_data),
    .thr_hi (hi_q),
    .thr_lo (lo_q),
    .lvl    (lvl_now)
  );

  assign ref_load = samp_valid && (!have_ref_q || resync);
  assign cmp_step = samp_valid && have_ref_q && !resync;
  assign changed  = (lvl_now != lvl_q);
  assign jump_now = is_jump(lvl_q, lvl_now);

  tlv_run_mon #(.MAX_RUN(MAX_RUN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ref (ref_load),
    .step     (cmp_step),
    .same     (!changed),
    .run_over (run_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      lvl_q      <= LV_ZERO;
      bit_valid  <= 1'b0;
      bit_out    <= 1'b0;
      jump_err   <= 1'b0;
      run_err    <= 1'b0;
    end else begin
      bit_valid <= cmp_step;
      bit_out   <= cmp_step && changed;
      jump_err  <= cmp_step && jump_now;
      run_err   <= run_over;
      if (samp_valid) begin
        lvl_q      <= lvl_now;
        have_ref_q <= 1'b1;
      end else if (resync) begin
        have_ref_q <= 1'b0;
      end
    end
  end

  assign lvl_out = lvl_q;

  // R3: the bit reports whether the level moved against the previous one
  p_bit_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (bit_out == (lvl_out != $past(lvl_out))));

  // R5: no bit without a sample in the cycle before
  p_valid_needs_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(samp_valid));

  // R4: a reference load never yields a bit
  p_ref_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load |=> !bit_valid);

  // R6: a swing flag comes only with a changed bit and an outer level
  p_jump_with_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_err |-> (bit_valid && bit_out && (lvl_out != LV_ZERO)));

  // R7: a run error comes only with an unchanged bit
  p_run_with_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_err |-> (bit_valid && !bit_out));

endmodule

// File: tb/test_tlv_rx_decode.sv
`timescale 1ns/1ps
module test_tlv_rx_decode;

  localparam int SW = 10;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n, resync, samp_valid, thr_wr;
  logic [SW-1:0] samp_data, thr_hi, thr_lo;
  logic bit_valid, bit_out, jump_err, run_err;
  logic [1:0] lvl_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlv_rx_decode #(.SAMPLE_W(SW), .MAX_RUN(3)) i_tlv_rx_decode (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .samp_valid(samp_valid), .samp_data(samp_data),
    .thr_wr(thr_wr), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .bit_valid(bit_valid), .bit_out(bit_out), .lvl_out(lvl_out),
    .jump_err(jump_err), .run_err(run_err)
  );

  // Samples at default thresholds +/-128; the first is the reference
  localparam int VS [NV] = '{0, 256, 200, 129, 128, -128, -129, -256,
                             0, 0, 0, 0, 5, 300, -300, 511, -512, 0};
  // Expected {valid, bit, jump, run, lvl[1:0]}
  localparam logic [5:0] VE [NV] = '{
    6'b0_0_0_0_00, 6'b1_1_0_0_01, 6'b1_0_0_0_01, 6'b1_0_0_0_01,
    6'b1_1_0_0_00, 6'b1_0_0_0_00, 6'b1_1_0_0_11, 6'b1_0_0_0_11,
    6'b1_1_0_0_00, 6'b1_0_0_0_00, 6'b1_0_0_0_00, 6'b1_0_0_1_00,
    6'b1_0_0_1_00, 6'b1_1_0_0_01, 6'b1_1_1_0_11, 6'b1_1_1_0_01,
    6'b1_1_1_0_11, 6'b1_1_0_0_00};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [5:0] e);
    chk({tag, " R3 bit_valid"}, int'(bit_valid), int'(e[5]));
    chk({tag, " R3 bit_out"},   int'(bit_out),   int'(e[4]));
    chk({tag, " R6 jump_err"},  int'(jump_err),  int'(e[3]));
    chk({tag, " R7 run_err"},   int'(run_err),   int'(e[2]));
    chk({tag, " R1 lvl_out"},   int'(lvl_out),   int'(e[1:0]));
  endtask

  // Drive one sample at a falling edge, check at the next falling edge
  task automatic send(input int s, input logic rs, input logic [5:0] e,
                      input string tag);
    samp_valid = 1'b1;
    samp_data  = SW'(s);
    resync     = rs;
    @(negedge clk);
    samp_valid = 1'b0;
    resync     = 1'b0;
    chk_all(tag, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 bit_valid in reset", int'(bit_valid), 0);
    chk("R8 bit_out in reset",   int'(bit_out),   0);
    chk("R8 jump_err in reset",  int'(jump_err),  0);
    chk("R8 run_err in reset",   int'(run_err),   0);
    chk("R8 lvl_out in reset",   int'(lvl_out),   0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; resync = 1'b0; samp_valid = 1'b0; thr_wr = 1'b0;
    samp_data = '0; thr_hi = '0; thr_lo = '0;
    @(negedge clk);
    do_reset();

    // Table walk, back to back; entry 0 is the reference (R4)
    for (int i = 0; i < NV; i++) begin
      samp_valid = 1'b1;
      samp_data  = SW'(VS[i]);
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), VE[i]);
    end
    samp_valid = 1'b0;

    // R5: idle cycles give no bit and keep the reference (last level 0, run 1)
    @(negedge clk);
    chk("R5 idle bit_valid", int'(bit_valid), 0);
    @(negedge clk);
    chk("R5 idle lvl_out", int'(lvl_out), 0);
    send(10, 1'b0, 6'b1_0_0_0_00, "R5 after idle");

    // R4: resync makes the sample a reference, next compares to it
    send(300, 1'b1, 6'b0_0_0_0_01, "R4 resync ref");
    send(-300, 1'b0, 6'b1_1_1_0_11, "R4 after resync");

    // R2: write in the same cycle as a sample; old thresholds apply to it
    thr_wr = 1'b1; thr_hi = SW'(50); thr_lo = SW'(-300);
    send(60, 1'b0, 6'b1_1_0_0_00, "R2 write cycle old thr");
    thr_wr = 1'b0;
    send(60, 1'b0, 6'b1_1_0_0_01, "R2 new hi");
    send(-200, 1'b0, 6'b1_1_0_0_00, "R2 new lo inside");
    send(-301, 1'b0, 6'b1_1_0_0_11, "R2 new lo below");

    // R8 and R2: reset restores defaults; 100 is zero again
    do_reset();
    send(100, 1'b0, 6'b0_0_0_0_00, "R2 default after reset ref");
    send(129, 1'b0, 6'b1_1_0_0_01, "R2 default hi");
    // R7: run of +1 from the reference onward
    send(129, 1'b0, 6'b1_0_0_0_01, "R7 run2");
    send(129, 1'b0, 6'b1_0_0_0_01, "R7 run3");
    send(129, 1'b0, 6'b1_0_0_1_01, "R7 run4");
    send(-129, 1'b0, 6'b1_1_1_0_11, "R6 after run");

    @(negedge clk);
    chk("R3 single pulse", int'(bit_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule